// File: doc/BRIEF.md
# Fractional Tick-Enable Divider

This block turns the system clock into a stream of one-cycle tick enables whose average spacing is a mixed number of clock cycles: an 8-bit whole part plus a 4-bit fraction in sixteenths. A counter that consumes the tick, such as a PWM period counter, can then be slowed by a non-integer ratio without a second clock domain. Tick spacing alternates between the whole part and the whole part plus one. A first-order phase accumulator decides which spacing each interval gets.

The divisor inputs are sampled while reset is held and again at every tick. A new ratio therefore never cuts short or stretches the interval already in progress. A whole part of zero is read as 256, and the fraction that comes with it is discarded. When the enable input is low, the block pauses: nothing advances, and no tick is issued.

Top module: `frac_tick_divider`

## Requirements
- R1: A synchronous active-low reset clears the interval counter and the fraction accumulator, holds `tick` low, and loads the divisor present on the inputs. The first interval after reset is exactly the whole part in enabled cycles.
- R2: With a fraction of 0 and a whole part N of 2 or more, `tick` is high on every Nth enabled cycle.
- R3: With a whole part of 1 and a fraction of 0, `tick` is high on every enabled cycle.
- R4: At each tick the 4-bit accumulator adds the fraction that is loaded at that tick. The interval that follows is the whole part plus the carry of that addition (0 or 1).
- R5: With a constant fraction F, any 16 consecutive intervals after the first contain exactly F intervals that are one cycle longer. Their total is 16·N + F cycles.
- R6: A whole part of 0 gives a whole part of 256, and the fraction is then treated as 0.
- R7: A divisor change in the middle of an interval leaves that interval's length unchanged. The new value governs from the next tick onward.
- R8: While `en` is low, the counter and the accumulator hold their values and `tick` stays low. Counting resumes from the held value when `en` returns.
- R9: `tick` is high only in an enabled cycle, for one cycle at a time, and the count restarts in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable; low pauses the divider |
| div_int | input | 8 | Whole part of the ratio; 0 means 256 |
| div_frac | input | 4 | Fractional part in sixteenths |
| tick | output | 1 | One-cycle enable at the end of each interval |

## Verification
Two events can fall in the same cycle. One is the last cycle of an interval, when the tick is due. The other is a drop of `en`, or a change on the divisor inputs. The bench drops `en` exactly in the cycle where the count sits at its limit, and judges that the tick is withheld and then appears in the first enabled cycle after `en` returns. It also changes `div_int` in the middle of an interval, and judges that the running interval keeps its old length and the next one takes the new length. Fraction sequences are compared interval by interval against a bench model of the accumulator carry.

// File: rtl/frac_div_pkg.sv
// Package: shared sizing for the fractional tick-enable divider.
// Assumes: the whole part and fraction widths are set once, here, and the
// counter is one bit wider than the whole part, so that 256 (or 257 with a
// carry) fits.
package frac_div_pkg;
    localparam int DEF_INT_W  = 8;
    localparam int DEF_FRAC_W = 4;
endpackage

// File: rtl/divisor_latch.sv
// Module: divisor_latch
// Holds the whole part of the ratio that governs the interval in progress.
// It captures the input while reset is held and again on each tick. It
// widens a zero whole part to 2**INT_W, and passes on a fraction that is
// forced to zero when the incoming whole part is zero.
// Assumes: load is a one-cycle pulse at interval boundaries.
module divisor_latch #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    localparam int CNT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [CNT_W-1:0]  whole_eff,
    output logic [FRAC_W-1:0] frac_in
);
    logic [INT_W-1:0] whole_q;

    // Capture the whole part during reset or at an interval boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            whole_q <= div_int;
        end
    end

    // Map a zero whole part to the largest ratio.
    always_comb begin
        if (whole_q == '0) begin
            whole_eff = CNT_W'(1) << INT_W;
        end else begin
            whole_eff = CNT_W'(whole_q);
        end
    end

    // A zero whole part makes the incoming fraction invalid: drop it.
    always_comb begin
        frac_in = (div_int == '0) ? '0 : div_frac;
    end
endmodule

// File: rtl/frac_accum.sv
// Module: frac_accum
// First-order phase accumulator. On each step it adds the incoming fraction
// and keeps the carry, which lengthens the next interval by one cycle.
// Assumes: step is high for exactly one cycle per tick.
module frac_accum #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [FRAC_W-1:0] add_frac,
    output logic [FRAC_W-1:0] acc_q,
    output logic              extra_q
);
    logic [FRAC_W:0] sum;

    // Widened sum, so that the carry is bit FRAC_W.
    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, add_frac};
    end

    // Update phase and carry only at a tick; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (step) begin
            acc_q   <= sum[FRAC_W-1:0];
            extra_q <= sum[FRAC_W];
        end
    end
endmodule

// File: rtl/interval_counter.sv
// Module: interval_counter
// Counts enabled cycles from zero up to a limit. In the enabled cycle where
// the count equals the limit it raises tick, and the count returns to zero.
// Assumes: the limit only changes in the cycle after a tick.
module interval_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tick
);
    logic at_limit;

    // Compare the running count with the current interval's last value.
    always_comb begin
        at_limit = (cnt_q == limit);
        tick     = rst_n && en && at_limit;
    end

    // Advance on enabled cycles, wrapping to zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/frac_tick_divider.sv
// Module: frac_tick_divider (top)
// Issues a one-cycle tick whose average spacing is div_int + div_frac/16
// enabled cycles. Each interval lasts the latched whole part plus the carry
// that the accumulator produced at the tick which opened that interval.
// Assumes: a synchronous active-low reset, held for at least one cycle.
module frac_tick_divider #(
    parameter int INT_W  = frac_div_pkg::DEF_INT_W,
    parameter int FRAC_W = frac_div_pkg::DEF_FRAC_W,
    localparam int CNT_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    logic [CNT_W-1:0]  whole_eff;
    logic [FRAC_W-1:0] frac_in;
    logic [FRAC_W-1:0] acc_q;
    logic              extra_q;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  cnt_q;

    divisor_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(tick),
        .div_int(div_int), .div_frac(div_frac),
        .whole_eff(whole_eff), .frac_in(frac_in)
    );

    frac_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .step(tick), .add_frac(frac_in),
        .acc_q(acc_q), .extra_q(extra_q)
    );

    // Last count value of this interval: whole part plus carry, minus one.
    always_comb begin
        limit = whole_eff + CNT_W'(extra_q) - CNT_W'(1);
    end

    interval_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .en(en), .limit(limit),
        .cnt_q(cnt_q), .tick(tick)
    );
endmodule

// File: rtl/frac_div_checker.sv
// Module: frac_div_checker
// Temporal checks on the divider, attached to every instance of the top
// through the bind at the end of this file.
// Assumes: cnt and acc are the interval count and accumulator phase.
module frac_div_checker #(
    parameter int CNT_W  = 9,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [FRAC_W-1:0] acc
);
    logic rst_seen_q;

    // Remember that reset was sampled at the previous edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            AST_RESET_CLEARS: assert (cnt == '0 && acc == '0) else $error("reset state"); // R1
        end
    end

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en) else $error("tick without enable"); // R9

    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0)) else $error("count did not restart"); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (cnt == $past(cnt) + CNT_W'(1))) else $error("count step"); // R2

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt) && $stable(acc))) else $error("moved while idle"); // R8

    AST_ACC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(acc)) else $error("accumulator moved between ticks"); // R4
endmodule

bind frac_tick_divider frac_div_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cnt(cnt_q), .acc(acc_q)
);

// File: tb/tb_frac_tick_divider.sv
module tb_frac_tick_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div_int = 8'd1;
    logic [3:0] div_frac = 4'd0;
    logic       tick;

    int checks = 0;
    int fails = 0;
    int acc_m = 0;
    int extra_m = 0;
    int whole_m = 1;

    frac_tick_divider dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .div_int(div_int), .div_frac(div_frac), .tick(tick)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int n);
        return (n == 0) ? 256 : n;
    endfunction

    // Reset with a given divisor; leaves the bench just after a negedge, enabled.
    task automatic do_reset(input int n, input int f);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1; div_int = 8'(n); div_frac = 4'(f);
        @(negedge clk);
        #1 check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
        @(negedge clk);
        rst_n = 1'b1;
        acc_m = 0; extra_m = 0; whole_m = n;
    endtask

    // One cycle: sample tick, then move to the next negedge.
    task automatic step(output bit t);
        #1 t = tick;
        @(negedge clk);
    endtask

    // Count enabled cycles up to and including the next tick.
    task automatic measure_gap(output int g);
        bit hit;
        g = 0;
        do begin
            #1 hit = tick;
            if (en) g++;
            @(negedge clk);
        end while (!hit && g < 1000);
    endtask

    // Model of R4: expected length of the current interval, then advance state.
    function automatic int model_next(input int n_port, input int f_port);
        int exp;
        int fe;
        exp = eff(whole_m) + extra_m;
        whole_m = n_port;
        fe = (n_port == 0) ? 0 : f_port;
        acc_m = acc_m + fe;
        extra_m = acc_m / 16;
        acc_m = acc_m % 16;
        return exp;
    endfunction

    task automatic t_reset();
        int g;
        do_reset(4, 0);
        measure_gap(g);
        check(g == 4, "R1 first interval", g, 4);
    endtask

    task automatic t_integer(input int n);
        int g;
        do_reset(n, 0);
        for (int k = 0; k < 3; k++) begin
            measure_gap(g);
            check(g == n, "R2 integer spacing", g, n);
        end
    endtask

    task automatic t_unity();
        bit t;
        do_reset(1, 0);
        for (int k = 0; k < 8; k++) begin
            step(t);
            check(t == 1'b1, "R3 tick every cycle", int'(t), 1);
        end
    endtask

    task automatic t_fraction(input int n, input int f);
        int g;
        int e;
        int total;
        do_reset(n, f);
        total = 0;
        for (int k = 0; k < 17; k++) begin
            e = model_next(n, f);
            measure_gap(g);
            check(g == e, "R4 interval after carry", g, e);
            if (k > 0) total += g;
        end
        check(total == 16 * eff(n) + f, "R5 sixteen-interval total", total, 16 * eff(n) + f);
    endtask

    task automatic t_zero_int();
        int g;
        do_reset(0, 9);
        for (int k = 0; k < 3; k++) begin
            measure_gap(g);
            check(g == 256, "R6 zero whole part", g, 256);
        end
    endtask

    task automatic t_reload();
        bit t;
        int g;
        do_reset(6, 0);
        step(t);
        step(t);
        div_int = 8'd3;
        measure_gap(g);
        check(g == 4, "R7 running interval kept", g, 4);
        measure_gap(g);
        check(g == 3, "R7 new ratio after tick", g, 3);
    endtask

    task automatic t_pause();
        bit t;
        int g;
        do_reset(5, 0);
        step(t);
        step(t);
        en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step(t);
            check(t == 1'b0, "R8 no tick while paused", int'(t), 0);
        end
        en = 1'b1;
        measure_gap(g);
        check(g == 3, "R8 count resumes", g, 3);
        // Pause exactly in the limit cycle.
        do_reset(2, 0);
        step(t);
        en = 1'b0;
        step(t);
        check(t == 1'b0, "R9 withheld at limit", int'(t), 0);
        en = 1'b1;
        step(t);
        check(t == 1'b1, "R9 tick on return", int'(t), 1);
        step(t);
        check(t == 1'b0, "R9 single-cycle tick", int'(t), 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_integer(10);
        t_integer(3);
        t_unity();
        t_fraction(4, 6);
        t_fraction(3, 5);
        t_fraction(1, 8);
        t_fraction(2, 15);
        t_zero_int();
        t_reload();
        t_pause();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule